// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor load/store port and a block-wide memory. Every request is looked up in both ways of one set at the same time. The set is selected by the block number modulo the set count. A hit is answered combinationally in the same cycle, without a stall. A write hit changes only the cached word and marks the line dirty. Memory is not written at that point.

On a miss the processor is stalled while the whole block is fetched. Writes allocate on a miss in the same way as reads. The way to replace is chosen as follows:

- an empty way, if the set has one;
- otherwise the way that one per-set recency bit marks as used less recently.

A dirty victim is copied into a one-entry write-back buffer. The refill read goes to memory first, and the old block is written afterwards. Hits continue to be served while that write drains. A second miss waits until the buffer is empty.

The processor holds `cpu_req` and its address until it sees `cpu_stall` low. The memory side holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack`. A one-cycle `mem_ack` completes the transfer and carries the read block on `mem_rdata`.

Top module: `two_way_wb_cache`

## Requirements
- R1: After reset every line is invalid and clean, and every recency bit is 0, so the first access to any address misses. With `cpu_req` low, `cpu_stall` and `mem_req` are low.
- R2: The set index is (`cpu_addr` / BLK_WORDS) mod SETS. The word within the block is `cpu_addr` mod BLK_WORDS. Both ways are compared at once, and a hit returns that word on `cpu_rdata` in the same cycle with `cpu_stall` low.
- R3: On a miss `cpu_stall` stays high until the block is installed. Exactly one read (`mem_we`=0) of block address `cpu_addr` / BLK_WORDS is issued, and the memory request is held stable until `mem_ack`. Word w of the block occupies `mem_rdata`/`mem_wdata` bits [w*DATA_W +: DATA_W].
- R4: A miss fills an invalid way when the set has one, so two blocks that share a set both stay resident after reset.
- R5: When both ways are valid, the victim is the way not most recently touched, where both hits and fills count as touches. With four blocks in two sets, the block sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss.
- R6: A write hit updates the cached word and marks the line dirty, and it issues no memory write.
- R7: Evicting a dirty line writes its whole block, with the latest data, to its own block address. Evicting a clean line writes nothing.
- R8: On a miss with a dirty victim, the refill read reaches memory before the write-back of the victim.
- R9: A write miss fetches the block, installs it and then applies the write. A later read of that word hits and returns the written value.
- R10: While the write-back buffer drains, hits are served without a stall. A miss waits until the drain completes and then reads memory contents that include the drained data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, held until not stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid when request is not stalled |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block refill read |
| mem_addr | output | ADDR_W-log2(BLK_WORDS) | Block address |
| mem_wdata | output | DATA_W*BLK_WORDS | Block being written back |
| mem_rdata | input | DATA_W*BLK_WORDS | Block returned by a read, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current transfer |

## Verification
The bench builds the cache with 6-bit word addresses, 16-bit words, two words per block and two sets. This gives 64 addresses, 32 blocks and four lines in total. At that size a long self-generated access stream visits every address many times. It drives every set through repeated dirty and clean evictions, invalid-way fills and recency flips.

The bench keeps its own coherent copy of memory, a model of the tags and recency bits, and the expected write-back blocks. Against these it checks hit or miss, returned data, read counts, write-back contents and ordering. A memory latency of three cycles keeps each write-back visibly pending while hits to other lines are issued.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    localparam int DEF_ADDR_W    = 12;
    localparam int DEF_DATA_W    = 32;
    localparam int DEF_BLK_WORDS = 4;
    localparam int DEF_SETS      = 16;

    typedef logic way_sel_t;

    typedef enum logic {
        CTL_LOOKUP,
        CTL_REFILL
    } ctl_state_e;

    // Empty way first (way 0 before way 1), else the recency pointer.
    function automatic way_sel_t pick_victim(input logic v0, input logic v1, input logic lru);
        if (!v0)      return 1'b0;
        else if (!v1) return 1'b1;
        else          return lru;
    endfunction

endpackage

// File: rtl/wbc_way.sv
module wbc_way
    import wbc_pkg::*;
#(
    parameter int SETS      = DEF_SETS,
    parameter int TAG_W     = 6,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int BLK_WORDS = DEF_BLK_WORDS,
    localparam int IDX_W    = $clog2(SETS),
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int LINE_W   = DATA_W * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit,
    output logic              valid,
    output logic              dirty,
    output logic [TAG_W-1:0]  tag_o,
    output logic [LINE_W-1:0] line_o
);

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (wr_en) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= tag;
            data_q[idx] <= fill_line;
        end else if (wr_en) begin
            data_q[idx][int'(wr_off)*DATA_W +: DATA_W] <= wr_data;
        end
    end

    assign valid  = valid_q[idx];
    assign dirty  = dirty_q[idx];
    assign tag_o  = tag_q[idx];
    assign line_o = data_q[idx];
    assign hit    = valid_q[idx] && (tag_q[idx] == tag);

endmodule

// File: rtl/wbc_lru.sv
module wbc_lru
    import wbc_pkg::*;
#(
    parameter int SETS   = DEF_SETS,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch,
    input  way_sel_t         touch_way,
    output logic             lru
);

    // Each bit names the way of its set that was not touched last.
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (touch) begin
            lru_q[idx] <= ~touch_way;
        end
    end

    assign lru = lru_q[idx];

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int BLK_AW = 10,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit_any,
    input  way_sel_t          hit_way,
    input  way_sel_t          victim_way,
    input  logic              victim_dirty,
    input  logic [BLK_AW-1:0] victim_blk,
    input  logic [LINE_W-1:0] victim_line,
    input  logic [BLK_AW-1:0] req_blk,
    input  logic              mem_ack,
    output logic              cpu_stall,
    output logic              fill_go,
    output way_sel_t          fill_way,
    output logic              wr_go,
    output logic              touch,
    output way_sel_t          touch_way,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BLK_AW-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    output logic              refilling,
    output logic              wb_pending
);

    typedef struct packed {
        logic [BLK_AW-1:0] blk;
        logic [LINE_W-1:0] line;
    } wb_entry_t;

    ctl_state_e state_q;
    way_sel_t   fill_way_q;
    logic       wb_valid_q;
    wb_entry_t  wb_q;

    logic lookup_hit;
    logic start_miss;

    assign lookup_hit = (state_q == CTL_LOOKUP) && cpu_req && hit_any;
    assign start_miss = (state_q == CTL_LOOKUP) && cpu_req && !hit_any && !wb_valid_q;
    assign cpu_stall  = cpu_req && !lookup_hit;
    assign fill_go    = (state_q == CTL_REFILL) && mem_ack;
    assign fill_way   = fill_way_q;
    assign wr_go      = lookup_hit && cpu_we;
    assign touch      = lookup_hit || fill_go;
    assign touch_way  = fill_go ? fill_way_q : hit_way;
    assign refilling  = (state_q == CTL_REFILL);
    assign wb_pending = wb_valid_q;

    // The refill owns the port; the write-back buffer drains otherwise.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_blk;
        mem_wdata = wb_q.line;
        if (state_q == CTL_REFILL) begin
            mem_req = 1'b1;
        end else if (wb_valid_q) begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = wb_q.blk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CTL_LOOKUP;
            fill_way_q <= 1'b0;
            wb_valid_q <= 1'b0;
            wb_q       <= '0;
        end else begin
            if (start_miss) begin
                state_q    <= CTL_REFILL;
                fill_way_q <= victim_way;
                if (victim_dirty) begin
                    wb_valid_q <= 1'b1;
                    wb_q.blk   <= victim_blk;
                    wb_q.line  <= victim_line;
                end
            end
            if (fill_go) begin
                state_q <= CTL_LOOKUP;
            end
            if ((state_q == CTL_LOOKUP) && wb_valid_q && mem_ack) begin
                wb_valid_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/two_way_wb_cache.sv
module two_way_wb_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int BLK_WORDS = DEF_BLK_WORDS,
    parameter int SETS      = DEF_SETS,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int IDX_W    = $clog2(SETS),
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W,
    localparam int BLK_AW   = ADDR_W - OFF_W,
    localparam int LINE_W   = DATA_W * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BLK_AW-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    logic [OFF_W-1:0]  off;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [BLK_AW-1:0] req_blk;

    assign off     = cpu_addr[OFF_W-1:0];
    assign idx     = cpu_addr[OFF_W +: IDX_W];
    assign tag     = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_blk = cpu_addr[ADDR_W-1:OFF_W];

    logic [1:0]        way_hit;
    logic [1:0]        way_valid;
    logic [1:0]        way_dirty;
    logic [TAG_W-1:0]  way_tag  [2];
    logic [LINE_W-1:0] way_line [2];

    logic     fill_go;
    way_sel_t fill_way;
    logic     wr_go;
    logic     touch;
    way_sel_t touch_way;
    logic     lru_bit;
    logic     refilling;
    logic     wb_pending;

    logic              hit_any;
    way_sel_t          hit_way;
    way_sel_t          victim_way;
    logic              victim_dirty;
    logic [BLK_AW-1:0] victim_blk;
    logic [LINE_W-1:0] victim_line;

    for (genvar g = 0; g < 2; g++) begin : g_way
        wbc_way #(
            .SETS      (SETS),
            .TAG_W     (TAG_W),
            .DATA_W    (DATA_W),
            .BLK_WORDS (BLK_WORDS)
        ) u_way (
            .clk       (clk),
            .rst       (rst),
            .idx       (idx),
            .tag       (tag),
            .fill_en   (fill_go && (fill_way == way_sel_t'(g))),
            .fill_line (mem_rdata),
            .wr_en     (wr_go && (hit_way == way_sel_t'(g))),
            .wr_off    (off),
            .wr_data   (cpu_wdata),
            .hit       (way_hit[g]),
            .valid     (way_valid[g]),
            .dirty     (way_dirty[g]),
            .tag_o     (way_tag[g]),
            .line_o    (way_line[g])
        );
    end

    wbc_lru #(.SETS(SETS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .idx       (idx),
        .touch     (touch),
        .touch_way (touch_way),
        .lru       (lru_bit)
    );

    assign hit_any      = |way_hit;
    assign hit_way      = way_hit[1];
    assign victim_way   = pick_victim(way_valid[0], way_valid[1], lru_bit);
    assign victim_dirty = way_valid[victim_way] && way_dirty[victim_way];
    assign victim_blk   = {way_tag[victim_way], idx};
    assign victim_line  = way_line[victim_way];
    assign cpu_rdata    = way_line[hit_way][int'(off)*DATA_W +: DATA_W];

    wbc_ctrl #(
        .BLK_AW (BLK_AW),
        .LINE_W (LINE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .hit_any      (hit_any),
        .hit_way      (hit_way),
        .victim_way   (victim_way),
        .victim_dirty (victim_dirty),
        .victim_blk   (victim_blk),
        .victim_line  (victim_line),
        .req_blk      (req_blk),
        .mem_ack      (mem_ack),
        .cpu_stall    (cpu_stall),
        .fill_go      (fill_go),
        .fill_way     (fill_way),
        .wr_go        (wr_go),
        .touch        (touch),
        .touch_way    (touch_way),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .refilling    (refilling),
        .wb_pending   (wb_pending)
    );

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
    parameter int BLK_AW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_stall,
    input logic [1:0]        way_hit,
    input logic              refilling,
    input logic              wb_pending,
    input logic              mem_req,
    input logic              mem_we,
    input logic [BLK_AW-1:0] mem_addr,
    input logic              mem_ack
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !mem_req && !wb_pending);

    assert_idle_no_stall_R1: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |-> !cpu_stall);

    assert_single_way_match_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));

    assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_req && (|way_hit) && !refilling |-> !cpu_stall);

    assert_miss_stalls_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_req && !(|way_hit) |-> cpu_stall);

    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

    assert_refill_before_wb_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_pending) |-> mem_req && !mem_we);

    assert_drain_while_idle_R10: assert property (@(posedge clk) disable iff (rst)
        wb_pending && !refilling |-> mem_req && mem_we);

endmodule

bind two_way_wb_cache wbc_checker #(.BLK_AW(BLK_AW)) u_wbc_checker (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_stall  (cpu_stall),
    .way_hit    (way_hit),
    .refilling  (refilling),
    .wb_pending (wb_pending),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack)
);

// File: tb/test_two_way_wb_cache.sv
module test_two_way_wb_cache;

    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int BW   = 2;
    localparam int NS   = 2;
    localparam int LAT  = 3;
    localparam int LW   = DW * BW;
    localparam int BAW  = AW - 1;
    localparam int NWD  = 64;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          cpu_req   = 1'b0;
    logic          cpu_we    = 1'b0;
    logic [AW-1:0] cpu_addr  = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_stall;
    logic          mem_req;
    logic          mem_we;
    logic [BAW-1:0] mem_addr;
    logic [LW-1:0] mem_wdata;
    logic [LW-1:0] mem_rdata;
    logic          mem_ack;

    two_way_wb_cache #(
        .ADDR_W (AW), .DATA_W (DW), .BLK_WORDS (BW), .SETS (NS)
    ) i_two_way_wb_cache (
        .clk (clk), .rst (rst),
        .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
        .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .cpu_stall (cpu_stall),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_ack (mem_ack)
    );

    function automatic logic [DW-1:0] init_word(input int i);
        return DW'(16'h1000 + i * 37);
    endfunction

    int tb_tests = 0;
    int tb_fails = 0;
    int mm_tests = 0;
    int mm_fails = 0;
    int rd_cnt   = 0;
    int wr_cnt   = 0;

    // Expected write-backs, pushed by the model, popped by the memory.
    logic [BAW-1:0] q_blk  [16];
    logic [LW-1:0]  q_line [16];
    int             q_mark [16];
    int             q_tail = 0;
    int             q_head = 0;

    logic [DW-1:0] mm [NWD];
    logic [DW-1:0] gm [NWD];
    int            cnt = 0;

    // Block memory with LAT cycles to acknowledge.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            cnt     <= 0;
            for (int i = 0; i < NWD; i++) mm[i] <= init_word(i);
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            cnt     <= 0;
        end else if (mem_req) begin
            if (cnt == LAT - 1) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int w = 0; w < BW; w++)
                        mm[int'(mem_addr) * BW + w] <= mem_wdata[w*DW +: DW];
                    wr_cnt   <= wr_cnt + 1;
                    mm_tests <= mm_tests + 1;
                    if (q_head == q_tail) begin
                        mm_fails <= mm_fails + 1;
                        $display("FAIL R7 unexpected write-back actual=blk %0d expected=none", mem_addr);
                    end else if (mem_addr != q_blk[q_head % 16] || mem_wdata != q_line[q_head % 16]) begin
                        mm_fails <= mm_fails + 1;
                        $display("FAIL R7 write-back actual=%0h:%0h expected=%0h:%0h",
                                 mem_addr, mem_wdata, q_blk[q_head % 16], q_line[q_head % 16]);
                    end else if (rd_cnt < q_mark[q_head % 16]) begin
                        mm_fails <= mm_fails + 1;
                        $display("FAIL R8 write-back before refill actual=reads %0d expected>=%0d",
                                 rd_cnt, q_mark[q_head % 16]);
                    end
                    q_head <= q_head + 1;
                end else begin
                    for (int w = 0; w < BW; w++)
                        mem_rdata[w*DW +: DW] <= mm[int'(mem_addr) * BW + w];
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    // Reference state of tags, validity, dirtiness and recency.
    logic rv [NS][2];
    logic rd [NS][2];
    int   rtag [NS][2];
    logic rlru [NS];

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        tb_tests++;
        if (!ok) begin
            tb_fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic ref_access(input logic we, input int addr, input logic [DW-1:0] wd,
                              output logic hit, output logic [DW-1:0] exp_rd);
        int blk, st, tg, hw;
        logic vw;
        blk = addr / BW;
        st  = blk % NS;
        tg  = blk / NS;
        hw  = -1;
        for (int w = 0; w < 2; w++) if (rv[st][w] && rtag[st][w] == tg) hw = w;
        if (hw < 0) begin
            hit = 1'b0;
            vw = !rv[st][0] ? 1'b0 : (!rv[st][1] ? 1'b1 : rlru[st]);
            if (rv[st][vw] && rd[st][vw]) begin
                int ob;
                ob = rtag[st][vw] * NS + st;
                q_blk[q_tail % 16]  = BAW'(ob);
                for (int w = 0; w < BW; w++) q_line[q_tail % 16][w*DW +: DW] = gm[ob * BW + w];
                q_mark[q_tail % 16] = rd_cnt + 1;
                q_tail++;
            end
            rv[st][vw]   = 1'b1;
            rd[st][vw]   = 1'b0;
            rtag[st][vw] = tg;
            hw = int'(vw);
        end else begin
            hit = 1'b1;
        end
        rlru[st] = (hw == 0);
        exp_rd = gm[addr];
        if (we) begin
            gm[addr]   = wd;
            rd[st][hw] = 1'b1;
        end
    endtask

    // Starts and ends on a falling edge; returns whether it hit at once.
    task automatic do_access(input logic we, input int addr, input logic [DW-1:0] wd,
                             input string what, output logic got_hit, output logic [DW-1:0] got);
        logic exp_hit;
        logic [DW-1:0] exp_rd;
        int r0;
        ref_access(we, addr, wd, exp_hit, exp_rd);
        r0 = rd_cnt;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = wd;
        #1;
        got_hit = !cpu_stall;
        while (cpu_stall) begin
            @(negedge clk);
            #1;
        end
        got = cpu_rdata;
        chk(got_hit == exp_hit, {what, " R5 hit/miss"}, 32'(got_hit), 32'(exp_hit));
        if (!we) chk(got == exp_rd, {what, " R3 read data"}, 32'(got), 32'(exp_rd));
        chk(rd_cnt - r0 == (exp_hit ? 0 : 1), {what, " R3 refill reads"}, 32'(rd_cnt - r0), exp_hit ? 0 : 1);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        $display("FAIL watchdog actual=%0d cycles expected=done", WDOG);
        $display("[TB] %0d tests run, %0d failed", tb_tests + mm_tests + 1, tb_fails + mm_fails + 1);
        $finish;
    end

    initial begin
        logic h;
        logic [DW-1:0] d;
        int wr0;
        int seed;
        for (int i = 0; i < NWD; i++) gm[i] = init_word(i);
        for (int s = 0; s < NS; s++) begin
            rlru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                rv[s][w] = 1'b0; rd[s][w] = 1'b0; rtag[s][w] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: quiet after reset
        chk(!cpu_stall, "R1 stall idle", 32'(cpu_stall), 0);
        chk(!mem_req, "R1 mem idle", 32'(mem_req), 0);
        @(negedge clk);

        // R5: blocks 0, 8, 0, 6, 8 -> miss, miss, hit, miss, miss
        do_access(1'b0, 0 * BW, '0, "seq0", h, d);  chk(h == 1'b0, "R5 blk0 first", 32'(h), 0);
        do_access(1'b0, 8 * BW, '0, "seq8", h, d);  chk(h == 1'b0, "R5 blk8 first", 32'(h), 0);
        do_access(1'b0, 0 * BW, '0, "seq0b", h, d); chk(h == 1'b1, "R5 blk0 again", 32'(h), 1);
        do_access(1'b0, 6 * BW, '0, "seq6", h, d);  chk(h == 1'b0, "R5 blk6", 32'(h), 0);
        do_access(1'b0, 8 * BW, '0, "seq8b", h, d); chk(h == 1'b0, "R5 blk8 again", 32'(h), 0);

        // R4 and R2: two blocks in set 1 both stay resident
        do_access(1'b0, 1 * BW + 1, '0, "r4a", h, d);
        do_access(1'b0, 3 * BW + 1, '0, "r4b", h, d);
        do_access(1'b0, 1 * BW + 1, '0, "r4c", h, d);
        chk(h == 1'b1 && d == init_word(3), "R4 blk1 resident", {h, 15'd0, d}, {1'b1, 15'd0, init_word(3)});
        do_access(1'b0, 3 * BW + 1, '0, "r4d", h, d);
        chk(h == 1'b1 && d == init_word(7), "R2 blk3 word1", {h, 15'd0, d}, {1'b1, 15'd0, init_word(7)});

        // R6: write hit touches only the cache
        wr0 = wr_cnt;
        do_access(1'b1, 1 * BW, 16'hBEEF, "r6w", h, d);
        chk(h == 1'b1, "R6 write hits", 32'(h), 1);
        do_access(1'b0, 1 * BW, '0, "r6r", h, d);
        chk(d == 16'hBEEF, "R6 write visible", 32'(d), 32'hBEEF);
        repeat (20) @(negedge clk);
        chk(wr_cnt == wr0, "R6 no memory write", 32'(wr_cnt), 32'(wr0));

        // R7, R8, R10: clean eviction of blk3, dirty eviction of blk1
        do_access(1'b0, 5 * BW, '0, "r7clean", h, d);
        repeat (10) @(negedge clk);
        chk(wr_cnt == wr0, "R7 clean eviction silent", 32'(wr_cnt), 32'(wr0));
        do_access(1'b0, 7 * BW, '0, "r7dirty", h, d);
        do_access(1'b0, 5 * BW + 1, '0, "r10hit", h, d);
        chk(h == 1'b1, "R10 hit during drain", 32'(h), 1);
        chk(mem_req && mem_we, "R10 drain pending", 32'({mem_req, mem_we}), 3);
        do_access(1'b0, 1 * BW, '0, "r10miss", h, d);
        chk(h == 1'b0 && d == 16'hBEEF, "R10 refetch drained data", {h, 15'd0, d}, {16'd0, 16'hBEEF});
        chk(wr_cnt == wr0 + 1, "R7 one write-back", 32'(wr_cnt), 32'(wr0 + 1));

        // R9: write miss allocates
        do_access(1'b1, 9 * BW + 1, 16'h5A5A, "r9w", h, d);
        chk(h == 1'b0, "R9 write misses", 32'(h), 0);
        do_access(1'b0, 9 * BW + 1, '0, "r9r", h, d);
        chk(h == 1'b1 && d == 16'h5A5A, "R9 allocated", {h, 15'd0, d}, {16'h8000, 16'h5A5A});

        // Sweep over every address with reads and writes.
        seed = 32'h1ACE;
        for (int n = 0; n < 1500; n++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >>> 17);
            seed = seed ^ (seed << 5);
            do_access(seed[9], (seed >>> 2) & 63, DW'(seed >>> 12), "sweep", h, d);
        end

        repeat (30) @(negedge clk);
        chk(q_head == q_tail, "R7 all write-backs drained", 32'(q_head), 32'(q_tail));
        chk(wr_cnt == q_tail, "R6 write count", 32'(wr_cnt), 32'(q_tail));

        $display("[TB] %0d tests run, %0d failed", tb_tests + mm_tests, tb_fails + mm_fails);
        $finish;
    end

endmodule